// File: doc/BRIEF.md
# PCIe Configuration Address Translator

This block turns one configuration-space access into the settings an outbound address translation unit needs. The access is given as bus, device and function numbers, a register offset and a read/write flag. Bus 0 is the root port itself, so those accesses are steered to the controller's own register window. Every other bus is reached through a configuration window. The window's target value holds the encoded bus/device/function, and its translation type selects a Type 0 or a Type 1 configuration cycle.

The root port has a single link. Only devices 0 and 1 can exist on bus 0, and only device 0 on bus 1. An access outside that set is filtered before it reaches the bus. A filtered read completes at once with all-ones data. A filtered write is dropped and flagged as an error. Each accepted request produces one registered result on the following clock. When no request arrives, the translation fields keep their last values.

Top module: `cfg_xlate`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. After reset, every output is 0.
- R2: `out_type` is 5'h04 (Type 0 configuration) when the request's bus number is 0 or 1, and 5'h05 (Type 1) when it is 2 or above.
- R3: `out_window` is 0 (local register window) for bus 0, and 1 (configuration window) for any other bus.
- R4: For a bus other than 0, `out_target` carries the bus in bits [31:24], the device in [23:19] and the function in [18:16], with bits [15:0] zero. For bus 0, `out_target` is 0.
- R5: `out_offset` equals the request offset with bits [1:0] forced to 0.
- R6: `out_invalid` is high for bus 0 with device above 1, and for bus 1 with device above 0. It is low for every other request.
- R7: An invalid read raises `out_rd_ones` and sets `out_rd_fill` to 32'hFFFFFFFF. Any other request sets `out_rd_fill` to 0 and leaves `out_rd_ones` low.
- R8: An invalid write raises `out_wr_err` and keeps `out_wr_go` low. A valid write raises `out_wr_go`. A read raises neither.
- R9: `out_ctrl` is 32'h80000000 (enable in bit 31, region index 0 in the low bits) for a valid request, and 0 for an invalid one.
- R10: In a cycle after `req_valid` is low, `out_invalid`, `out_rd_ones`, `out_wr_err` and `out_wr_go` are 0. `out_window`, `out_type`, `out_target`, `out_offset`, `out_ctrl` and `out_rd_fill` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_offset | input | 12 | Register byte offset |
| out_valid | output | 1 | Result present |
| out_window | output | 1 | 0 = local register window, 1 = configuration window |
| out_type | output | 5 | Translation type code |
| out_target | output | 32 | Translation target value |
| out_offset | output | 12 | Dword-aligned offset |
| out_ctrl | output | 32 | Region control word |
| out_invalid | output | 1 | Request addressed a device that cannot exist |
| out_rd_ones | output | 1 | Invalid read completed with all ones |
| out_rd_fill | output | 32 | Read completion data for a filtered read |
| out_wr_err | output | 1 | Invalid write rejected |
| out_wr_go | output | 1 | Valid write may proceed |

## Verification
A wrong decode shows up one cycle after the request, on the same result. A bad bus compare flips `out_type` or `out_window` at the bus 0/1/2 boundaries. A bad shift misplaces `out_target` bits. A wrong device limit shows as `out_invalid` together with a wrong `out_ctrl`, and the error and fill flags follow. A broken hold path stays hidden until an idle cycle comes after a request, and it then shows as changed data fields. The bench therefore hits every boundary device and bus, interleaves idle cycles, and compares every output on every clock.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] XT_CFG_T0 = 5'h04;
  localparam logic [TYPE_W-1:0] XT_CFG_T1 = 5'h05;

  typedef enum logic {
    WIN_LOCAL = 1'b0,
    WIN_CFG   = 1'b1
  } win_e;
endpackage

// File: rtl/cfg_bdf_filter.sv
module cfg_bdf_filter #(
  parameter int BUS_W        = 8,
  parameter int DEV_W        = 5,
  parameter int BUS0_MAX_DEV = 1,
  parameter int BUS1_MAX_DEV = 0
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  output logic             bad
);
  localparam logic [DEV_W-1:0] LIM0 = DEV_W'(BUS0_MAX_DEV);
  localparam logic [DEV_W-1:0] LIM1 = DEV_W'(BUS1_MAX_DEV);

  always_comb begin
    bad = 1'b0;
    if (bus == BUS_W'(0) && dev > LIM0) bad = 1'b1;
    if (bus == BUS_W'(1) && dev > LIM1) bad = 1'b1;
  end
endmodule

// File: rtl/cfg_xlate_encode.sv
module cfg_xlate_encode
  import cfg_xlate_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int DEV_W      = 5,
  parameter int FN_W       = 3,
  parameter int OFS_W      = 12,
  parameter int DATA_W     = 32,
  parameter int T1_BUS_MIN = 2
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FN_W-1:0]   fn,
  input  logic [OFS_W-1:0]  ofs,
  output logic              win,
  output logic [TYPE_W-1:0] xtype,
  output logic [DATA_W-1:0] target,
  output logic [OFS_W-1:0]  ofs_al
);
  localparam int BDF_W   = BUS_W + DEV_W + FN_W;
  localparam int TGT_LSB = DATA_W - BDF_W;

  logic [BDF_W-1:0] bdf;
  assign bdf = {bus, dev, fn};

  always_comb begin
    xtype  = (bus < BUS_W'(T1_BUS_MIN)) ? XT_CFG_T0 : XT_CFG_T1;
    win    = (bus == '0) ? WIN_LOCAL : WIN_CFG;
    target = '0;
    if (bus != '0) target[DATA_W-1:TGT_LSB] = bdf;
    ofs_al = {ofs[OFS_W-1:2], 2'b00};
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int BUS_W        = 8,
  parameter int DEV_W        = 5,
  parameter int FN_W         = 3,
  parameter int OFS_W        = 12,
  parameter int DATA_W       = 32,
  parameter int BUS0_MAX_DEV = 1,
  parameter int BUS1_MAX_DEV = 0,
  parameter int T1_BUS_MIN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_func,
  input  logic [OFS_W-1:0]  req_offset,
  output logic              out_valid,
  output logic              out_window,
  output logic [4:0]        out_type,
  output logic [DATA_W-1:0] out_target,
  output logic [OFS_W-1:0]  out_offset,
  output logic [DATA_W-1:0] out_ctrl,
  output logic              out_invalid,
  output logic              out_rd_ones,
  output logic [DATA_W-1:0] out_rd_fill,
  output logic              out_wr_err,
  output logic              out_wr_go
);
  localparam logic [DATA_W-1:0] CTRL_EN = DATA_W'(1) << (DATA_W - 1);

  logic              bad;
  logic              n_win;
  logic [TYPE_W-1:0] n_type;
  logic [DATA_W-1:0] n_target;
  logic [OFS_W-1:0]  n_ofs;

  cfg_bdf_filter #(
    .BUS_W(BUS_W), .DEV_W(DEV_W),
    .BUS0_MAX_DEV(BUS0_MAX_DEV), .BUS1_MAX_DEV(BUS1_MAX_DEV)
  ) u_filter (
    .bus(req_bus), .dev(req_dev), .bad(bad)
  );

  cfg_xlate_encode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFS_W(OFS_W),
    .DATA_W(DATA_W), .T1_BUS_MIN(T1_BUS_MIN)
  ) u_encode (
    .bus(req_bus), .dev(req_dev), .fn(req_func), .ofs(req_offset),
    .win(n_win), .xtype(n_type), .target(n_target), .ofs_al(n_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_rd_ones <= 1'b0;
      out_wr_err  <= 1'b0;
      out_wr_go   <= 1'b0;
      out_window  <= 1'b0;
      out_type    <= '0;
      out_target  <= '0;
      out_offset  <= '0;
      out_ctrl    <= '0;
      out_rd_fill <= '0;
    end else begin
      out_valid   <= req_valid;
      out_invalid <= req_valid & bad;
      out_rd_ones <= req_valid & bad & ~req_write;
      out_wr_err  <= req_valid & bad & req_write;
      out_wr_go   <= req_valid & ~bad & req_write;
      if (req_valid) begin
        out_window  <= n_win;
        out_type    <= n_type;
        out_target  <= n_target;
        out_offset  <= n_ofs;
        out_ctrl    <= bad ? '0 : CTRL_EN;
        out_rd_fill <= (bad && !req_write) ? '1 : '0;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R10
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid && !out_invalid && !out_wr_go && !out_wr_err);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_target) && $stable(out_offset) && $stable(out_ctrl));
  // R2
  type_sel_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_type == (($past(req_bus) < BUS_W'(T1_BUS_MIN)) ? XT_CFG_T0 : XT_CFG_T1));
  // R5
  ofs_align_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_offset[1:0] == 2'b00 && out_offset[OFS_W-1:2] == $past(req_offset[OFS_W-1:2]));
  // R8
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_rd_ones, out_wr_err, out_wr_go}));
  // R7
  fill_ones_chk: assert property (@(posedge clk) disable iff (rst)
    out_rd_ones |-> out_rd_fill == '1);
  // R9
  ctrl_off_chk: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_ctrl == '0);
endmodule

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [11:0] req_offset;
  logic        out_valid, out_window, out_invalid, out_rd_ones, out_wr_err, out_wr_go;
  logic [4:0]  out_type;
  logic [31:0] out_target, out_ctrl, out_rd_fill;
  logic [11:0] out_offset;

  int checks = 0;
  int fails  = 0;

  // expected state
  bit        e_valid, e_win, e_inv, e_ones, e_err, e_go;
  int        e_type;
  bit [31:0] e_target, e_ctrl, e_fill;
  bit [11:0] e_ofs;

  always #2 clk = ~clk;

  cfg_xlate u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_offset(req_offset),
    .out_valid(out_valid), .out_window(out_window), .out_type(out_type),
    .out_target(out_target), .out_offset(out_offset), .out_ctrl(out_ctrl),
    .out_invalid(out_invalid), .out_rd_ones(out_rd_ones), .out_rd_fill(out_rd_fill),
    .out_wr_err(out_wr_err), .out_wr_go(out_wr_go)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 valid",    32'(out_valid),   32'(e_valid));
    chk("R3 window",   32'(out_window),  32'(e_win));
    chk("R2 type",     32'(out_type),    32'(e_type));
    chk("R4 target",   out_target,       e_target);
    chk("R5 offset",   32'(out_offset),  32'(e_ofs));
    chk("R9 ctrl",     out_ctrl,         e_ctrl);
    chk("R6 invalid",  32'(out_invalid), 32'(e_inv));
    chk("R7 rd_ones",  32'(out_rd_ones), 32'(e_ones));
    chk("R7 rd_fill",  out_rd_fill,      e_fill);
    chk("R8 wr_err",   32'(out_wr_err),  32'(e_err));
    chk("R8 wr_go",    32'(out_wr_go),   32'(e_go));
  endtask

  // one clock: check outputs from the previous request, then drive a new one
  task automatic step(input bit v, input bit w, input int bus, input int dev,
                      input int fn, input int ofs);
    bit bad;
    @(negedge clk);
    compare_all();
    req_valid = v; req_write = w; req_bus = 8'(bus); req_dev = 5'(dev);
    req_func = 3'(fn); req_offset = 12'(ofs);
    bad = (bus == 0 && dev > 1) || (bus == 1 && dev > 0);
    e_valid = v;
    e_inv   = v && bad;
    e_ones  = v && bad && !w;
    e_err   = v && bad && w;
    e_go    = v && !bad && w;
    if (v) begin
      e_win    = (bus != 0);
      e_type   = (bus < 2) ? 4 : 5;
      e_target = (bus == 0) ? 32'h0 : ((32'(bus) << 24) | (32'(dev) << 19) | (32'(fn) << 16));
      e_ofs    = 12'(ofs) & 12'hFFC;
      e_ctrl   = bad ? 32'h0 : 32'h8000_0000;
      e_fill   = (bad && !w) ? 32'hFFFF_FFFF : 32'h0;
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0;
    req_func = 0; req_offset = 0;
    e_valid = 0; e_win = 0; e_inv = 0; e_ones = 0; e_err = 0; e_go = 0;
    e_type = 0; e_target = 0; e_ctrl = 0; e_fill = 0; e_ofs = 0;
    repeat (3) @(negedge clk);
    compare_all(); // R1 reset state
    rst = 1'b0;
    // bus 0 boundary devices (R3, R6, R7, R8)
    step(1, 0, 0, 0, 0, 12'h004);
    step(1, 1, 0, 1, 7, 12'h013);
    step(1, 0, 0, 2, 0, 12'h010);
    step(1, 1, 0, 31, 3, 12'h0FF);
    step(0, 0, 9, 9, 1, 12'h777);   // R10 hold
    // bus 1 boundary (R2 type 0, R6)
    step(1, 1, 1, 0, 5, 12'h102);
    step(1, 0, 1, 1, 0, 12'h200);
    step(1, 1, 1, 1, 2, 12'h201);
    // bus 2 and top end (R2 type 1, R4)
    step(1, 0, 2, 5, 3, 12'hFFF);
    step(1, 1, 255, 31, 7, 12'h003);
    step(0, 1, 0, 31, 0, 12'h000);  // R10 hold after write
    step(0, 0, 3, 3, 3, 12'h333);
    // mixed pattern
    for (int i = 0; i < 400; i++) begin
      int b;
      b = ($urandom % 3 == 0) ? int'($urandom % 256) : int'($urandom % 3);
      step(($urandom % 4) != 0, $urandom % 2, b, $urandom % 32, $urandom % 8, $urandom % 4096);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule